// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking a two-level page table held in memory. A translation request carries the logical address. The walker splits the address into three fields: a 12-bit outer index, a 10-bit inner index and a 10-bit page offset. It first checks the outer index against the configured table length. It then reads one outer entry and one inner entry through a single-beat memory read port.

The outer entry points to the page that holds the inner table. The inner entry supplies the frame number. On success the physical address is the frame number with the unchanged offset appended. If the walk stops early, the response is a fault with a code that tells which check failed. The table base and table length come from configuration inputs. These inputs must stay stable while a walk is in progress.

Top module: `pt_walker`

## Requirements
- R1: The logical address splits into an offset in bits 9:0, an inner index in bits 19:10 and an outer index in bits 31:20.
- R2: A table entry is 32 bits. Bit 0 is the valid flag, bits 31:10 hold the pointer, and bits 9:1 are ignored. The outer read address is the table base plus 4 times the outer index. The inner read address is {outer pointer, 10'b0} plus 4 times the inner index.
- R3: An outer index equal to or greater than the table length ends the walk with fault code 1. No memory read is issued, and the response appears on the first rising edge after acceptance.
- R4: An outer entry with valid flag 0 ends the walk with fault code 2 after exactly one memory read.
- R5: An inner entry with valid flag 0 ends the walk with fault code 3.
- R6: A successful walk returns fault 0, code 0, and a physical address of {inner pointer, offset}.
- R7: At most one memory read is outstanding at a time. While a read request waits for ready, it stays valid with a stable address.
- R8: The request port is ready only when the walker is idle. A request presented during a walk is ignored.
- R9: The response valid signal is a one-cycle pulse. The walker returns to idle on the next edge. When memory accepts each read at once and answers in the following cycle, a successful response rises at the fourth rising edge after the accepting edge.
- R10: During and right after reset, req_ready is 1, rsp_valid is 0 and mem_rd_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this edge |
| req_vaddr | input | 32 | Logical address to translate |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | 1 when the walk failed |
| rsp_code | output | 2 | 0 success, 1 length, 2 outer invalid, 3 inner invalid |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry read from memory |
| cfg_tbl_base | input | 32 | Byte address of the outer table |
| cfg_tbl_len | input | 13 | Number of legal outer entries |

## Verification
The embedded properties check several rules on every cycle. A waiting read holds its valid and address, and a request is never offered during a walk. The response lasts exactly one cycle. A length violation faults on the next edge, and an invalid outer entry leads to code 2. A successful address always keeps the requested offset. Some behaviour can only be shown by the bench's scenarios, because each depends on table contents built for it:
- the full translated value and the arithmetic of both entry addresses;
- the exact response latency;
- the ignoring of reserved entry bits;
- the length bound at zero and at its maximum;
- operation under a memory that stalls.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_LEN   = 2'd1,
    FLT_OUTER = 2'd2,
    FLT_INNER = 2'd3
  } flt_code_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_OUTER,
    ST_RD_INNER,
    ST_DONE,
    ST_FAULT
  } walk_st_e;
endpackage

// File: rtl/ptw_index_calc.sv
module ptw_index_calc #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 10,
  parameter int IN_W  = 10,
  parameter int ENT_W = 32,
  parameter int LEN_W = VA_W - OFF_W - IN_W + 1
) (
  input  logic [VA_W-1:0]        vaddr,
  input  logic [ENT_W-1:0]       tbl_base,
  input  logic [LEN_W-1:0]       tbl_len,
  input  logic [ENT_W-OFF_W-1:0] next_ptr,
  output logic [ENT_W-1:0]       outer_addr,
  output logic [ENT_W-1:0]       inner_addr,
  output logic                   len_viol,
  output logic [OFF_W-1:0]       offset
);
  localparam int OUT_W    = VA_W - OFF_W - IN_W;
  localparam int ENT_SHFT = $clog2(ENT_W / 8);

  function automatic logic [OUT_W-1:0] f_outer(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: OUT_W];
  endfunction

  function automatic logic [IN_W-1:0] f_inner(input logic [VA_W-1:0] va);
    return va[OFF_W +: IN_W];
  endfunction

  function automatic logic [ENT_W-1:0] f_slot(input logic [ENT_W-1:0] base,
                                               input logic [ENT_W-1:0] idx);
    return base + (idx << ENT_SHFT);
  endfunction

  always_comb begin
    outer_addr = f_slot(tbl_base, ENT_W'(f_outer(vaddr)));
    inner_addr = f_slot({next_ptr, {OFF_W{1'b0}}}, ENT_W'(f_inner(vaddr)));
    len_viol   = LEN_W'(f_outer(vaddr)) >= tbl_len;
    offset     = vaddr[OFF_W-1:0];
  end
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
  parameter int ENT_W = 32,
  parameter int OFF_W = 10
) (
  input  logic [ENT_W-1:0]       entry,
  output logic                   vld,
  output logic [ENT_W-OFF_W-1:0] ptr
);
  logic ent_unused;
  assign vld        = entry[0];
  assign ptr        = entry[ENT_W-1:OFF_W];
  assign ent_unused = ^entry[OFF_W-1:1];
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       len_viol,
  output logic       mem_rd_valid,
  input  logic       mem_rd_ready,
  input  logic       mem_rsp_valid,
  input  logic       ent_vld,
  output logic       rd_inner,
  output logic       ptr_load,
  output logic       frame_load,
  output logic       rsp_valid,
  output logic       rsp_fault,
  output logic [1:0] rsp_code
);
  walk_st_e  st_q, st_d;
  flt_code_e code_q, code_d;
  logic      iss_q, iss_d;
  logic      take;

  assign take = iss_q && mem_rsp_valid;

  always_comb begin
    st_d   = st_q;
    iss_d  = iss_q;
    code_d = code_q;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (len_viol) begin
            st_d   = ST_FAULT;
            code_d = FLT_LEN;
          end else begin
            st_d = ST_RD_OUTER;
          end
        end
      end
      ST_RD_OUTER, ST_RD_INNER: begin
        if (!iss_q) begin
          if (mem_rd_ready) iss_d = 1'b1;
        end else if (mem_rsp_valid) begin
          iss_d = 1'b0;
          if (!ent_vld) begin
            st_d = ST_FAULT;
            if (st_q == ST_RD_OUTER) code_d = FLT_OUTER;
            else                     code_d = FLT_INNER;
          end else if (st_q == ST_RD_OUTER) begin
            st_d = ST_RD_INNER;
          end else begin
            st_d = ST_DONE;
          end
        end
      end
      default: begin
        st_d   = ST_IDLE;
        code_d = FLT_NONE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      iss_q  <= 1'b0;
      code_q <= FLT_NONE;
    end else begin
      st_q   <= st_d;
      iss_q  <= iss_d;
      code_q <= code_d;
    end
  end

  assign req_ready    = (st_q == ST_IDLE);
  assign rd_inner     = (st_q == ST_RD_INNER);
  assign mem_rd_valid = ((st_q == ST_RD_OUTER) || (st_q == ST_RD_INNER)) && !iss_q;
  assign ptr_load     = (st_q == ST_RD_OUTER) && take && ent_vld;
  assign frame_load   = (st_q == ST_RD_INNER) && take && ent_vld;
  assign rsp_valid    = (st_q == ST_DONE) || (st_q == ST_FAULT);
  assign rsp_fault    = (st_q == ST_FAULT);
  assign rsp_code     = (st_q == ST_FAULT) ? code_q : FLT_NONE;

  // R7: a read that waits for ready stays requested
  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid) else $error("rd hold");
  // R8: no request offered while a read is pending
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !req_ready) else $error("busy ready");
  // R3: length violation faults on the next edge
  p_len_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && len_viol |=> rsp_valid && rsp_fault && rsp_code == FLT_LEN)
    else $error("len fault");
  // R4: invalid outer entry gives code 2
  p_outer_flt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RD_OUTER) && take && !ent_vld |=> rsp_fault && rsp_code == FLT_OUTER)
    else $error("outer fault");
  // R9: response is a single-cycle pulse followed by idle
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready) else $error("pulse");
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 10,
  parameter int IN_W  = 10,
  parameter int ENT_W = 32,
  parameter int LEN_W = VA_W - OFF_W - IN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [1:0]       rsp_code,
  output logic [ENT_W-1:0] rsp_paddr,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [ENT_W-1:0] mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data,
  input  logic [ENT_W-1:0] cfg_tbl_base,
  input  logic [LEN_W-1:0] cfg_tbl_len
);
  localparam int PTR_W = ENT_W - OFF_W;

  logic [VA_W-1:0]  va_q, va_sel;
  logic [PTR_W-1:0] ptr_q, frame_q, ent_ptr;
  logic [ENT_W-1:0] outer_addr, inner_addr;
  logic [OFF_W-1:0] offset;
  logic             len_viol, ent_vld, rd_inner, ptr_load, frame_load;

  assign va_sel = req_ready ? req_vaddr : va_q;

  ptw_index_calc #(.VA_W(VA_W), .OFF_W(OFF_W), .IN_W(IN_W), .ENT_W(ENT_W), .LEN_W(LEN_W)) idx_i (
    .vaddr(va_sel), .tbl_base(cfg_tbl_base), .tbl_len(cfg_tbl_len), .next_ptr(ptr_q),
    .outer_addr(outer_addr), .inner_addr(inner_addr), .len_viol(len_viol), .offset(offset));

  ptw_entry_decode #(.ENT_W(ENT_W), .OFF_W(OFF_W)) dec_i (
    .entry(mem_rsp_data), .vld(ent_vld), .ptr(ent_ptr));

  ptw_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .len_viol(len_viol), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rsp_valid(mem_rsp_valid), .ent_vld(ent_vld), .rd_inner(rd_inner),
    .ptr_load(ptr_load), .frame_load(frame_load), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_code(rsp_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q    <= '0;
      ptr_q   <= '0;
      frame_q <= '0;
    end else begin
      if (req_valid && req_ready) va_q <= req_vaddr;
      if (ptr_load)               ptr_q <= ent_ptr;
      if (frame_load)             frame_q <= ent_ptr;
    end
  end

  assign mem_rd_addr = rd_inner ? inner_addr : outer_addr;
  assign rsp_paddr   = rsp_fault ? '0 : {frame_q, offset};

  // R7: address of a waiting read does not move
  p_rd_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> $stable(mem_rd_addr)) else $error("rd addr");
  // R6: a successful result keeps the requested offset
  p_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]) else $error("offset");
endmodule

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid, rsp_fault;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_paddr;
  logic        mem_rd_valid, mem_rd_ready, mem_rsp_valid;
  logic [31:0] mem_rd_addr, mem_rsp_data;
  logic [31:0] cfg_tbl_base = 32'h0001_0000;
  logic [12:0] cfg_tbl_len  = 13'd8;

  int n_chk = 0, n_fail = 0, rd_count = 0;
  bit stall_mode = 0, done = 0;
  int rsp_lat = 0;
  logic [31:0] addr_prev, addr_last;
  logic [31:0] mem [logic [31:0]];

  always #2 clk = ~clk;

  pt_walker dut_i (.*);

  function automatic logic [31:0] ent(input logic [21:0] ptr, input logic [9:0] low);
    return {ptr, low};
  endfunction

  function automatic logic [31:0] lookup(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder: one read at a time, fixed response latency
  initial begin : mem_model
    bit pend = 0, tog = 0;
    int wcnt = 0;
    logic [31:0] pa = '0;
    mem_rd_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (wcnt == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = lookup(pa); pend = 0;
        end else wcnt--;
      end
      tog = ~tog;
      mem_rd_ready = stall_mode ? tog : 1'b1;
      if (mem_rd_valid && mem_rd_ready) begin
        pend = 1; pa = mem_rd_addr; wcnt = rsp_lat; rd_count++;
        addr_prev = addr_last; addr_last = mem_rd_addr;
      end
    end
  end

  task automatic walk(input logic [31:0] va, input bit junk,
                      output logic f, output logic [1:0] c, output logic [31:0] pa,
                      output int lat, output int nrd, output bit rdy_busy);
    int base;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; base = rd_count; lat = 0; rdy_busy = 0;
    do begin
      @(negedge clk);
      req_valid = junk; req_vaddr = ~va;
      lat++;
      if (!rsp_valid && req_ready) rdy_busy = 1;
    end while (!rsp_valid && lat < 200);
    f = rsp_fault; c = rsp_code; pa = rsp_paddr; nrd = rd_count - base;
    req_valid = 1'b0;
  endtask

  // vectors: R1 field split, R2 entry format, R4/R5/R6 outcomes, R3 bound
  localparam int NV = 8;
  localparam logic [31:0] V_VA [NV] = '{
    {12'd0, 10'd0,    10'h155}, {12'd0, 10'd1023, 10'h3FF},
    {12'd0, 10'd7,    10'h02A}, {12'd1, 10'd0,    10'h123},
    {12'd5, 10'd3,    10'h010}, {12'd7, 10'd0,    10'h000},
    {12'd8, 10'd0,    10'h000}, {12'hFFF, 10'd0,  10'h3FF}};
  localparam logic [1:0] V_CODE [NV] = '{2'd0, 2'd0, 2'd3, 2'd2, 2'd0, 2'd2, 2'd1, 2'd1};
  localparam logic [31:0] V_PA [NV] = '{
    {22'h12345, 10'h155}, {22'h3FFFFF, 10'h3FF}, 32'h0, 32'h0,
    {22'h000ABC, 10'h010}, 32'h0, 32'h0, 32'h0};

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic f; logic [1:0] c; logic [31:0] pa; int lat, nrd; bit rb;
    mem[32'h0001_0000] = ent(22'h80, 10'h001);
    mem[32'h0001_0004] = ent(22'h99, 10'h000);
    mem[32'h0001_0014] = ent(22'hC1, 10'h001);
    mem[32'h0002_0000] = ent(22'h12345, 10'h001);
    mem[32'h0002_0FFC] = ent(22'h3FFFFF, 10'h001);
    mem[32'h0002_001C] = ent(22'h55, 10'h000);
    mem[32'h0003_040C] = ent(22'hABC, 10'h3FF);

    repeat (3) @(negedge clk);
    chk("R10 req_ready in reset", {31'b0, req_ready}, 32'd1);
    chk("R10 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 mem_rd_valid after reset", {31'b0, mem_rd_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      walk(V_VA[i], 1'b0, f, c, pa, lat, nrd, rb);
      chk($sformatf("R1/R6 v%0d fault", i), {31'b0, f}, {31'b0, V_CODE[i] != 2'd0});
      chk($sformatf("R3/R4/R5 v%0d code", i), {30'b0, c}, {30'b0, V_CODE[i]});
      chk($sformatf("R6 v%0d paddr", i), pa, V_PA[i]);
      if (i == 0) chk("R9 latency", lat, 5);
      if (i == 3) chk("R4 one read", nrd, 1);
      if (i == 4) begin
        chk("R2 outer address", addr_prev, 32'h0001_0014);
        chk("R2 inner address", addr_last, 32'h0003_040C);
      end
      if (i == 6) begin
        chk("R3 latency", lat, 1);
        chk("R3 no read", nrd, 0);
      end
    end

    // R8: request held during walk is ignored, ready stays low
    walk(V_VA[4], 1'b1, f, c, pa, lat, nrd, rb);
    chk("R8 ignored request", pa, V_PA[4]);
    chk("R8 ready low while busy", {31'b0, rb}, 32'd0);
    @(negedge clk);
    chk("R9 one-cycle pulse", {31'b0, rsp_valid}, 32'd0);

    // R7: stalling memory with slow response
    stall_mode = 1; rsp_lat = 3;
    walk(V_VA[1], 1'b0, f, c, pa, lat, nrd, rb);
    chk("R7 stalled paddr", pa, V_PA[1]);
    chk("R7 stalled reads", nrd, 2);
    walk(V_VA[2], 1'b0, f, c, pa, lat, nrd, rb);
    chk("R5 stalled code", {30'b0, c}, 32'd3);
    stall_mode = 0; rsp_lat = 0;

    // R3 bounds: zero length, and maximum length
    cfg_tbl_len = 13'd0;
    walk(V_VA[0], 1'b0, f, c, pa, lat, nrd, rb);
    chk("R3 zero length code", {30'b0, c}, 32'd1);
    cfg_tbl_len = 13'h1000;
    walk(V_VA[7], 1'b0, f, c, pa, lat, nrd, rb);
    chk("R3 max length passes bound", {30'b0, c}, 32'd2);
    chk("R3 max length reads", nrd, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule